// File: doc/BRIEF.md
# SPI EEPROM Host Write Sequencer

This block sits between user logic and a serial EEPROM on an SPI bus. User logic hands it one request at a time over a valid/ready handshake: a write of one byte to an address, or a read of one or more consecutive bytes starting at an address. The block turns each request into the command frames the memory expects and drives the serial clock, the active-low chip select and the outgoing data line. It samples the incoming data line on the rising clock edge.

Writes are guarded against the memory's slow internal programming. Each write first sends a write-enable frame, then the write frame. After that the block reads the status register over and over until its busy bit drops. Only then does it pulse `done` and accept the next request. If the busy bit stays set past a cycle limit, `done` comes with `err`. Reads send the address once and then clock in the requested number of bytes. These bytes come out as a stream, and the final byte is flagged. After reset, chip select stays high for a set number of cycles before the first frame. Every pair of frames is separated by a minimum chip-select high time.

Top module: `eeprom_wr_seq`

## Requirements
- R1: After reset, `cs_n` stays high and `req_ready` stays low for at least PWRUP_CYCLES clock cycles.
- R2: Every write request first produces a one-byte frame carrying opcode 0x06, with `cs_n` returning high before the next frame.
- R3: The write frame is four bytes: opcode 0x02, address bits 15:8, address bits 7:0, then the data byte, each sent MSB first.
- R4: After the write frame, frames of two bytes (opcode 0x05 plus a dummy byte) repeat until the second byte's bit 0 reads 0. No other frame is sent until then, and `req_ready` stays low.
- R5: If bit 0 is still 1 when a poll ends and WIP_TIMEOUT cycles have passed since polling began, the request ends with `done` and `err` high together.
- R6: A read request sends one frame: opcode 0x03, address high byte, address low byte, then `req_len`+1 data bytes with no second address. Each byte appears on `rd_data` with `rd_valid`, and `rd_last` is set on the final byte only.
- R7: While `cs_n` is high, `sck` rests at its idle level, which is the MODE3 parameter (0 for mode 0, 1 for mode 3). Incoming data is sampled on the rising edge of `sck`.
- R8: Each `sck` level, while a frame is active, lasts at least CLK_DIV clock cycles.
- R9: Between two frames, `cs_n` is high for at least CS_GAP clock cycles.
- R10: Every accepted request ends with exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write one byte, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Read byte count minus one |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final byte of the read |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | Busy-bit timeout, valid with `done` |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
A wrong frame kind or byte index shows up on the bus within one frame: the memory model logs a wrong opcode, a missing write-enable frame or a wrong frame length. A wrong read-back bit can also reveal it. A stuck poll loop or a lost busy flag shows up as an early or missing `done`, or as a false `err`. In the worst case this takes the timeout window. A clock divider or gap-timer fault breaks the half-period or chip-select-high minimum on the very next edge. Each of these is measured on every cycle.

// File: rtl/eepseq_pkg.sv
package eepseq_pkg;

  typedef enum logic [1:0] {FR_WREN, FR_WRITE, FR_POLL, FR_READ} frame_e;
  typedef enum logic [1:0] {ST_PWR, ST_IDLE, ST_ACT, ST_GAP} seq_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;

  // index of the final byte of a frame; n is read byte count minus one
  function automatic logic [15:0] frame_last(frame_e k, logic [15:0] n);
    case (k)
      FR_WREN:  return 16'd0;
      FR_WRITE: return 16'd3;
      FR_POLL:  return 16'd1;
      default:  return 16'd3 + n;
    endcase
  endfunction

  // byte to shift out at position idx of a frame
  function automatic logic [7:0] tx_byte(frame_e k, logic [15:0] idx,
                                         logic [15:0] a, logic [7:0] d);
    case (k)
      FR_WREN: return OP_WREN;
      FR_POLL: return (idx == 16'd0) ? OP_RDSR : 8'h00;
      FR_WRITE: begin
        case (idx)
          16'd0:   return OP_WRITE;
          16'd1:   return a[15:8];
          16'd2:   return a[7:0];
          default: return d;
        endcase
      end
      default: begin
        case (idx)
          16'd0:   return OP_READ;
          16'd1:   return a[15:8];
          16'd2:   return a[7:0];
          default: return 8'h00;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/eeprom_wait_ctr.sv
module eeprom_wait_ctr #(
  parameter int W       = 8,
  parameter int RST_VAL = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= W'(RST_VAL);
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // a load never reads as expired on the following cycle when a wait is asked for
  p_load_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/eeprom_spi_shift.sv
module eeprom_spi_shift #(
  parameter int CLK_DIV = 7,
  parameter bit MODE3   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  // mode 3 ends on the last rising edge; mode 0 needs a trailing low half
  localparam logic [4:0] LAST_HALF = MODE3 ? 5'd15 : 5'd16;

  logic [DW-1:0] div_q;
  logic [4:0]    half_q;
  logic [7:0]    sh_q, rx_q;
  logic          sck_q, busy_q, done_q;
  logic          half_end;

  assign half_end = busy_q && (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; half_q <= '0; sh_q <= '0; rx_q <= '0;
      sck_q <= MODE3; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1; half_q <= '0; div_q <= '0; sh_q <= tx; sck_q <= 1'b0;
      end else if (busy_q) begin
        if (!half_end) div_q <= div_q + 1'b1;
        else begin
          div_q <= '0;
          if (half_q == LAST_HALF) begin
            busy_q <= 1'b0; done_q <= 1'b1;
          end else begin
            half_q <= half_q + 1'b1;
            if (!half_q[0]) begin
              sck_q <= 1'b1;
              rx_q  <= {rx_q[6:0], miso};
            end else begin
              sck_q <= 1'b0;
              if (half_q != 5'd15) sh_q <= {sh_q[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = sh_q[7];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  generate
    if (CLK_DIV > 1) begin : g_hold
      p_half_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q != $past(sck_q)) |=> (sck_q == $past(sck_q)));
    end
  endgenerate
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eepseq_pkg::*;
#(
  parameter int CLK_DIV      = 7,
  parameter bit MODE3        = 1'b0,
  parameter int CS_GAP       = 7,
  parameter int PWRUP_CYCLES = 200,
  parameter int WIP_TIMEOUT  = 1000000,
  parameter int ADDR_W       = 16,
  parameter int LEN_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_last,
  output logic              done,
  output logic              err,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int WAIT_MAX = (PWRUP_CYCLES > CS_GAP) ? PWRUP_CYCLES : CS_GAP;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 2);
  localparam int TMO_W    = $clog2(WIP_TIMEOUT + 2);

  seq_state_e       st_q;
  frame_e           kind_q, next_kind;
  logic [15:0]      bidx_q, addr_q, len_q, last_idx;
  logic [7:0]       wdata_q, tx_d, eng_rx;
  logic [TMO_W-1:0] tmo_q;
  logic cs_q, go_q, wip_q, done_q, err_q, rdv_q, rdl_q;
  logic [7:0] rdd_q;
  logic eng_busy, eng_done, wait_done;
  // named internal events
  logic start_frame, finish, fail, frame_end, tmo_hit, accept;

  assign last_idx  = frame_last(kind_q, len_q);
  assign tx_d      = tx_byte(kind_q, bidx_q, addr_q, wdata_q);
  assign frame_end = (st_q == ST_ACT) && eng_done && (bidx_q == last_idx);
  assign tmo_hit   = (tmo_q >= TMO_W'(WIP_TIMEOUT));
  assign accept    = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    start_frame = 1'b0; finish = 1'b0; fail = 1'b0; next_kind = kind_q;
    if (accept) begin
      start_frame = 1'b1;
      next_kind   = req_write ? FR_WREN : FR_READ;
    end else if (st_q == ST_GAP && wait_done) begin
      case (kind_q)
        FR_WREN:  begin start_frame = 1'b1; next_kind = FR_WRITE; end
        FR_WRITE: begin start_frame = 1'b1; next_kind = FR_POLL;  end
        FR_POLL: begin
          if (!wip_q)       finish = 1'b1;
          else if (tmo_hit) begin finish = 1'b1; fail = 1'b1; end
          else              start_frame = 1'b1;
        end
        default: finish = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PWR; kind_q <= FR_WREN; bidx_q <= '0; addr_q <= '0; len_q <= '0;
      wdata_q <= '0; tmo_q <= '0; cs_q <= 1'b1; go_q <= 1'b0; wip_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; rdv_q <= 1'b0; rdl_q <= 1'b0; rdd_q <= '0;
    end else begin
      go_q   <= start_frame;
      done_q <= finish;
      err_q  <= fail;
      rdv_q  <= 1'b0;
      rdl_q  <= 1'b0;
      if (st_q == ST_PWR && wait_done) st_q <= ST_IDLE;
      if (accept) begin
        addr_q  <= 16'(req_addr);
        len_q   <= 16'(req_len);
        wdata_q <= req_wdata;
      end
      if (start_frame) begin
        st_q <= ST_ACT; cs_q <= 1'b0; bidx_q <= '0; kind_q <= next_kind;
      end
      if (finish) st_q <= ST_IDLE;
      if (st_q == ST_ACT && eng_done) begin
        if (kind_q == FR_READ && bidx_q >= 16'd3) begin
          rdv_q <= 1'b1; rdd_q <= eng_rx; rdl_q <= (bidx_q == last_idx);
        end
        if (kind_q == FR_POLL && bidx_q == 16'd1) wip_q <= eng_rx[0];
        if (frame_end) begin
          cs_q <= 1'b1; st_q <= ST_GAP;
        end else begin
          bidx_q <= bidx_q + 16'd1; go_q <= 1'b1;
        end
      end
      if (start_frame && kind_q == FR_WRITE) tmo_q <= '0;
      else if (kind_q == FR_POLL && !tmo_hit) tmo_q <= tmo_q + 1'b1;
    end
  end

  eeprom_wait_ctr #(.W(WAIT_W), .RST_VAL(PWRUP_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(frame_end),
    .load_val(WAIT_W'(CS_GAP)), .expired(wait_done));

  eeprom_spi_shift #(.CLK_DIV(CLK_DIV), .MODE3(MODE3)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(go_q), .tx(tx_d), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx(eng_rx));

  assign req_ready = (st_q == ST_IDLE);
  assign cs_n      = cs_q;
  assign done      = done_q;
  assign err       = err_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign rd_last   = rdl_q;

  p_sck_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == MODE3));
  p_ready_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
  p_cs_rise_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  p_engine_idle_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !cs_n);
endmodule

// File: tb/eeprom_wr_seq_bench.sv
module eeprom_wr_seq_bench;
  localparam int  CLK_DIV = 3;
  localparam bit  MODE3   = 1'b1;
  localparam int  CS_GAP  = 5;
  localparam int  PWRUP   = 40;
  localparam int  TMO     = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_len = '0, req_wdata = '0;
  logic req_ready, rd_valid, rd_last, done, err, sck, cs_n, mosi, miso;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  eeprom_wr_seq #(.CLK_DIV(CLK_DIV), .MODE3(MODE3), .CS_GAP(CS_GAP),
    .PWRUP_CYCLES(PWRUP), .WIP_TIMEOUT(TMO)) u_eeprom_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .done(done), .err(err), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso));

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory on the bus ----------------
  typedef struct packed {logic [7:0] op; logic [15:0] len; logic [15:0] addr; logic [7:0] d;} frame_t;
  frame_t flog[$];
  logic [7:0] fr[$];
  logic [7:0] mem [0:255];
  logic [7:0] cur_out = 8'h00;
  int bitc = 0, polls_cfg = 0, wip_left = 0;
  bit wel = 0;
  logic [15:0] pend_a = '0;
  logic [7:0]  pend_d = '0;
  logic [7:0]  shreg = '0;

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);

  assign miso = cur_out[3'(7 - bitc)];

  always @(negedge cs_n) begin
    bitc = 0; cur_out = 8'h00; fr.delete();
  end

  always @(posedge sck) if (cs_n === 1'b0) begin
    shreg = {shreg[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      fr.push_back(shreg);
      cur_out = 8'h00;
      if (fr[0] == 8'h05) cur_out = {7'b0, wip_left > 0};
      if (fr[0] == 8'h03 && fr.size() >= 3)
        cur_out = mem[8'(fr[2] + 8'(fr.size() - 3))];
    end
  end

  always @(posedge cs_n) begin
    if (fr.size() > 0) begin
      frame_t rec;
      rec.op = fr[0]; rec.len = 16'(fr.size());
      rec.addr = (fr.size() >= 3) ? {fr[1], fr[2]} : 16'h0;
      rec.d = (fr.size() >= 4) ? fr[3] : 8'h00;
      flog.push_back(rec);
      if (fr[0] == 8'h06) wel = 1;
      else if (fr[0] == 8'h02 && wel && fr.size() == 4) begin
        wel = 0; pend_a = {fr[1], fr[2]}; pend_d = fr[3];
        if (polls_cfg == 0) mem[pend_a[7:0]] = pend_d;
        else wip_left = polls_cfg;
      end else if (fr[0] == 8'h05 && wip_left > 0) begin
        wip_left--;
        if (wip_left == 0) mem[pend_a[7:0]] = pend_d;
      end
    end
    fr.delete();
  end

  // ---------------- per-cycle monitors ----------------
  int cyc = 0, first_fall = -1, cs_high_run = 0, gap_viol = 0, half_viol = 0;
  int idle_viol = 0, busy_viol = 0, done_cnt = 0, last_since = 0, req_cnt = 0;
  bit busy = 0, last_err = 0, fin = 0;
  logic prev_sck = MODE3, prev_cs = 1'b1;
  logic [7:0] rdq_d[$];
  bit rdq_l[$];

  always @(negedge clk) if (rst_n) begin
    cyc++;
    last_since++;
    if (cs_n && sck !== MODE3) idle_viol++;
    if (sck !== prev_sck) begin
      if (!cs_n && last_since < CLK_DIV) half_viol++;
      last_since = 0;
    end
    if (cs_n) cs_high_run++;
    if (prev_cs && !cs_n) begin
      if (first_fall < 0) first_fall = cyc;
      else if (cs_high_run < CS_GAP) gap_viol++;
      cs_high_run = 0;
    end
    if (done) begin done_cnt++; last_err = err; busy = 0; end
    else if (busy && req_ready) busy_viol++;
    if (rd_valid) begin rdq_d.push_back(rd_data); rdq_l.push_back(rd_last); end
    prev_sck = sck; prev_cs = cs_n;
  end

  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic do_req(input bit wr, input logic [15:0] a, input logic [7:0] n,
                        input logic [7:0] d, output int took);
    int start_done, t0;
    start_done = done_cnt;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = n; req_wdata = d;
    while (!req_ready) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    req_valid = 0; busy = 1; req_cnt++;
    took = 0;
    while (done_cnt == start_done && took < 40000) begin @(negedge clk); took++; end
    took = cyc - t0;
  endtask

  task automatic chk_frame(input int i, input logic [7:0] op, input int len,
                           input logic [15:0] a, input logic [7:0] d, input string req);
    if (i >= flog.size()) begin chk(0, req, flog.size(), i + 1); return; end
    chk(flog[i].op == op, req, flog[i].op, op);
    chk(flog[i].len == 16'(len), req, flog[i].len, len);
    if (len >= 3) chk(flog[i].addr == a, req, flog[i].addr, a);
    if (len >= 4 && op == 8'h02) chk(flog[i].d == d, req, flog[i].d, d);
  endtask

  initial begin
    int took;
    repeat (3) @(negedge clk);
    // R1: quiet reset state
    chk(cs_n === 1'b1, "R1 cs_n after reset", cs_n, 1);
    chk(req_ready === 1'b0, "R1 ready during power-up", req_ready, 0);
    chk(sck === MODE3, "R7 idle sck level", sck, MODE3);
    chk(done === 1'b0, "R10 no done in reset", done, 0);
    rst_n = 1;
    while (!req_ready) @(negedge clk);
    chk(cyc >= PWRUP, "R1 power-up hold", cyc, PWRUP);

    // R2 R3 R4: write with two busy polls
    polls_cfg = 2; flog.delete();
    do_req(1'b1, 16'h0012, 8'd0, 8'hA5, took);
    chk(last_err == 0, "R4 write ends clean", last_err, 0);
    chk(flog.size() == 5, "R4 poll frame count", flog.size(), 5);
    chk_frame(0, 8'h06, 1, 16'h0, 8'h0, "R2 write enable first");
    chk_frame(1, 8'h02, 4, 16'h0012, 8'hA5, "R3 write frame");
    for (int i = 2; i < 5; i++) chk_frame(i, 8'h05, 2, 16'h0, 8'h0, "R4 status poll");
    chk(mem[8'h12] == 8'hA5, "R3 byte stored", mem[8'h12], 8'hA5);

    // R4 boundary: not busy at first poll
    polls_cfg = 0; flog.delete();
    do_req(1'b1, 16'h0013, 8'd0, 8'h3C, took);
    chk(flog.size() == 3, "R4 single poll", flog.size(), 3);
    chk_frame(1, 8'h02, 4, 16'h0013, 8'h3C, "R3 second write");
    chk_frame(2, 8'h05, 2, 16'h0, 8'h0, "R4 single poll op");

    // R6: sequential read of four bytes
    flog.delete(); rdq_d.delete(); rdq_l.delete();
    do_req(1'b0, 16'h0010, 8'd3, 8'h00, took);
    chk(flog.size() == 1, "R6 one read frame", flog.size(), 1);
    chk_frame(0, 8'h03, 7, 16'h0010, 8'h0, "R6 read frame no address resend");
    chk(rdq_d.size() == 4, "R6 byte count", rdq_d.size(), 4);
    if (rdq_d.size() == 4) begin
      chk(rdq_d[0] == init_val(16), "R6 byte0", rdq_d[0], init_val(16));
      chk(rdq_d[1] == init_val(17), "R6 byte1", rdq_d[1], init_val(17));
      chk(rdq_d[2] == 8'hA5, "R6 byte2", rdq_d[2], 8'hA5);
      chk(rdq_d[3] == 8'h3C, "R6 byte3", rdq_d[3], 8'h3C);
      chk(rdq_l[3] && !rdq_l[0] && !rdq_l[1] && !rdq_l[2], "R6 last flag",
          {rdq_l[0], rdq_l[1], rdq_l[2], rdq_l[3]}, 1);
    end

    // R6 boundary: single byte read
    flog.delete(); rdq_d.delete(); rdq_l.delete();
    do_req(1'b0, 16'h00FF, 8'd0, 8'h00, took);
    chk(rdq_d.size() == 1, "R6 single read count", rdq_d.size(), 1);
    if (rdq_d.size() == 1) begin
      chk(rdq_d[0] == init_val(255), "R6 single read data", rdq_d[0], init_val(255));
      chk(rdq_l[0] == 1, "R6 single read last", rdq_l[0], 1);
    end

    // R5: memory never finishes programming
    polls_cfg = 1000000; flog.delete();
    do_req(1'b1, 16'h0040, 8'd0, 8'h77, took);
    chk(last_err == 1, "R5 timeout err", last_err, 1);
    chk(took >= TMO, "R5 timeout not early", took, TMO);
    chk(flog.size() >= 4, "R5 polled before giving up", flog.size(), 4);
    wip_left = 0;

    repeat (10) @(negedge clk);
    chk(done_cnt == req_cnt, "R10 one done per request", done_cnt, req_cnt);
    chk(idle_viol == 0, "R7 sck idle while deselected", idle_viol, 0);
    chk(half_viol == 0, "R8 half period minimum", half_viol, 0);
    chk(gap_viol == 0, "R9 chip select gap", gap_viol, 0);
    chk(busy_viol == 0, "R4 ready held low while busy", busy_viol, 0);
    finish_run();
  end
endmodule